// File: doc/BRIEF.md
# Decode-Time Branch Redirect Unit

This block sits in the decode stage, in the path between the incoming group of instructions from fetch and the group that goes on to rename. Each cycle it looks at up to `LANES` entries in program order. For every entry that is a direct, unconditional control transfer, it adds the encoded offset to the PC to get the real target. That target replaces the entry's next-PC and is compared with the next-PC that the front end predicted. An entry that the front end predicted taken but that is not a control instruction at all is also caught.

The earliest entry that fails either test becomes the offender. It is still forwarded, and every entry after it is held back for that cycle. The block produces a redirect record for fetch: thread, sequence number, corrected next-PC, a taken bit, and a flag that marks the non-control case. Later entries of the same thread with larger sequence numbers are reported as killed. If fetch is currently held for the offender's thread, an unblock pulse for that thread goes out with the redirect. Entries with no source operands are marked ready to issue. Two running counters record resolved branches and redirects.

All outputs are registered. A group presented before a rising edge shows its results after that edge.

Top module: `bru_redirect_unit`

## Requirements
- R1: A forwarded entry with control, direct and unconditional flags all set leaves with next-PC equal to PC plus offset (modulo 2^PC_W). Any other forwarded entry that is not an offender leaves with its predicted next-PC unchanged.
- R2: When a resolved entry's computed target differs from its predicted next-PC, `rd_valid` is set. `rd_npc` is the computed target, and `rd_tid` and `rd_seq` are the entry's thread and sequence number.
- R3: `rd_taken` is 1 exactly when `rd_npc` differs from the offender's PC plus 4 (the fixed instruction size).
- R4: An entry predicted taken whose control flag is clear is an offender. It raises `rd_valid` and `rd_ctrl_err`, and both `rd_npc` and its forwarded next-PC equal its PC plus 4.
- R5: On a redirect, each live entry after the offender that has the same thread and a strictly greater sequence number (unsigned) has its bit set in `out_kill`. Killed entries are not forwarded.
- R6: The earliest offender in lane order wins. The offender and all live entries before it are forwarded, and no entry after it is forwarded in that cycle.
- R7: `fe_unblock` has bit t set, and only that bit, when a redirect for thread t fires while `thr_hold[t]` is 1. Otherwise it is all zero.
- R8: `out_rdy[i]` is 1 exactly when lane i is forwarded and its no-source flag is set.
- R9: A lane with `in_skip` set, or with `in_vld` clear, is neither forwarded nor evaluated, so it can never cause a redirect.
- R10: `cnt_resolved` grows by the number of forwarded resolved entries in each group. `cnt_mispred` grows by one for each redirect.
- R11: Every output is zero during and right after reset. Results appear one clock edge after their input group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | LANES | Lane holds an entry |
| in_skip | input | LANES | Entry was already squashed upstream |
| in_tid | input | LANES*TID_W | Thread per lane |
| in_seq | input | LANES*SEQ_W | Sequence number per lane |
| in_pc | input | LANES*PC_W | PC per lane |
| in_off | input | LANES*PC_W | Encoded branch offset per lane |
| in_ctrl | input | LANES | Entry is a control transfer |
| in_direct | input | LANES | Target is PC-relative |
| in_uncond | input | LANES | Transfer is unconditional |
| in_ptaken | input | LANES | Front end predicted taken |
| in_pnpc | input | LANES*PC_W | Predicted next-PC per lane |
| in_nosrc | input | LANES | Entry reads no source register |
| thr_hold | input | 2^TID_W | Fetch currently held (blocked or unblocking) per thread |
| out_vld | output | LANES | Entry forwarded to rename |
| out_npc | output | LANES*PC_W | Next-PC of each forwarded entry |
| out_rdy | output | LANES | Forwarded entry may issue at once |
| out_kill | output | LANES | Entry squashed by this group's redirect |
| rd_valid | output | 1 | Redirect (mispredict, squash) to fetch |
| rd_tid | output | TID_W | Offender's thread |
| rd_seq | output | SEQ_W | Offender's sequence number |
| rd_npc | output | PC_W | Corrected next-PC |
| rd_taken | output | 1 | Corrected path is not the fall-through |
| rd_ctrl_err | output | 1 | Offender was a non-control entry predicted taken |
| fe_unblock | output | 2^TID_W | Unblock pulse to fetch per thread |
| cnt_resolved | output | CNT_W | Resolved-branch count |
| cnt_mispred | output | CNT_W | Redirect count |

## Verification
Every result of a group, whether forwarding, kill mask, ready bits, redirect record, unblock pulse or counter step, is due exactly one rising edge after the group is applied. The bench changes inputs on a falling edge and compares all outputs on the next falling edge. At that point only the one intervening rising edge has captured the group. The next group is applied at that same falling edge, so each counter step belongs to exactly one group. The sweep covers every mix of five lane kinds across four lanes, which reaches every offender position, the skip case and the fall-through-target (not taken) case.

// File: rtl/bru_pkg.sv
package bru_pkg;
    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        LN_PASS     = 2'd0,
        LN_RESOLVED = 2'd1,
        LN_MISPRED  = 2'd2,
        LN_CTRLERR  = 2'd3
    } ln_cls_e;

    function automatic logic is_offender(input ln_cls_e c);
        return (c == LN_MISPRED) || (c == LN_CTRLERR);
    endfunction
endpackage

// File: rtl/bru_lane_eval.sv
module bru_lane_eval
    import bru_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            act,
    input  logic            ctrl,
    input  logic            direct,
    input  logic            uncond,
    input  logic            ptaken,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] off,
    input  logic [PC_W-1:0] pnpc,
    output ln_cls_e         cls,
    output logic [PC_W-1:0] npc
);
    logic [PC_W-1:0] fall;
    logic [PC_W-1:0] tgt;

    always_comb begin
        fall = pc + PC_W'(INSN_BYTES);
        tgt  = pc + off;
        cls  = LN_PASS;
        npc  = pnpc;
        if (act && ctrl && direct && uncond) begin
            npc = tgt;
            cls = (tgt != pnpc) ? LN_MISPRED : LN_RESOLVED;
        end else if (act && ptaken && !ctrl) begin
            npc = fall;
            cls = LN_CTRLERR;
        end
    end
endmodule

// File: rtl/bru_first_hit.sv
module bru_first_hit #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] hit_vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bru_redirect_unit.sv
module bru_redirect_unit
    import bru_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PC_W  = 16,
    parameter int SEQ_W = 8,
    parameter int TID_W = 1,
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         in_vld,
    input  logic [LANES-1:0]         in_skip,
    input  logic [LANES*TID_W-1:0]   in_tid,
    input  logic [LANES*SEQ_W-1:0]   in_seq,
    input  logic [LANES*PC_W-1:0]    in_pc,
    input  logic [LANES*PC_W-1:0]    in_off,
    input  logic [LANES-1:0]         in_ctrl,
    input  logic [LANES-1:0]         in_direct,
    input  logic [LANES-1:0]         in_uncond,
    input  logic [LANES-1:0]         in_ptaken,
    input  logic [LANES*PC_W-1:0]    in_pnpc,
    input  logic [LANES-1:0]         in_nosrc,
    input  logic [(1<<TID_W)-1:0]    thr_hold,
    output logic [LANES-1:0]         out_vld,
    output logic [LANES*PC_W-1:0]    out_npc,
    output logic [LANES-1:0]         out_rdy,
    output logic [LANES-1:0]         out_kill,
    output logic                     rd_valid,
    output logic [TID_W-1:0]         rd_tid,
    output logic [SEQ_W-1:0]         rd_seq,
    output logic [PC_W-1:0]          rd_npc,
    output logic                     rd_taken,
    output logic                     rd_ctrl_err,
    output logic [(1<<TID_W)-1:0]    fe_unblock,
    output logic [CNT_W-1:0]         cnt_resolved,
    output logic [CNT_W-1:0]         cnt_mispred
);
    localparam int NTHR  = 1 << TID_W;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int NRS_W = $clog2(LANES + 1);

    typedef struct packed {
        logic             valid;
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  npc;
        logic             taken;
        logic             ctrl_err;
    } redirect_t;

    logic [LANES-1:0] act;
    logic [LANES-1:0] hit_vec;
    ln_cls_e          cls  [LANES];
    logic [PC_W-1:0]  npc_w[LANES];

    assign act = in_vld & ~in_skip;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bru_lane_eval #(.PC_W(PC_W)) u_eval (
            .act   (act[g]),
            .ctrl  (in_ctrl[g]),
            .direct(in_direct[g]),
            .uncond(in_uncond[g]),
            .ptaken(in_ptaken[g]),
            .pc    (in_pc[g*PC_W +: PC_W]),
            .off   (in_off[g*PC_W +: PC_W]),
            .pnpc  (in_pnpc[g*PC_W +: PC_W]),
            .cls   (cls[g]),
            .npc   (npc_w[g])
        );
        assign hit_vec[g] = is_offender(cls[g]);
    end

    logic             hit;
    logic [IDX_W-1:0] hidx;

    bru_first_hit #(.LANES(LANES)) u_pick (
        .hit_vec(hit_vec),
        .any    (hit),
        .idx    (hidx)
    );

    logic [LANES-1:0] fwd, kill;
    logic [NRS_W-1:0] nres;
    redirect_t        rd_n;
    logic [PC_W-1:0]  off_pc;
    logic [NTHR-1:0]  unblk_n;

    always_comb begin
        rd_n.valid    = hit;
        rd_n.tid      = in_tid[hidx*TID_W +: TID_W];
        rd_n.seq      = in_seq[hidx*SEQ_W +: SEQ_W];
        rd_n.npc      = npc_w[hidx];
        off_pc        = in_pc[hidx*PC_W +: PC_W];
        rd_n.taken    = rd_n.npc != (off_pc + PC_W'(INSN_BYTES));
        rd_n.ctrl_err = cls[hidx] == LN_CTRLERR;
        unblk_n       = hit ? (thr_hold & (NTHR'(1) << rd_n.tid)) : '0;
        nres          = '0;
        for (int i = 0; i < LANES; i++) begin
            logic after;
            after   = hit && (i > int'(hidx));
            fwd[i]  = act[i] && !after;
            kill[i] = act[i] && after
                      && (in_tid[i*TID_W +: TID_W] == rd_n.tid)
                      && (in_seq[i*SEQ_W +: SEQ_W] > rd_n.seq);
            if (fwd[i] && (cls[i] == LN_RESOLVED || cls[i] == LN_MISPRED))
                nres = nres + NRS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld      <= '0;
            out_npc      <= '0;
            out_rdy      <= '0;
            out_kill     <= '0;
            rd_valid     <= 1'b0;
            rd_tid       <= '0;
            rd_seq       <= '0;
            rd_npc       <= '0;
            rd_taken     <= 1'b0;
            rd_ctrl_err  <= 1'b0;
            fe_unblock   <= '0;
            cnt_resolved <= '0;
            cnt_mispred  <= '0;
        end else begin
            out_vld  <= fwd;
            out_rdy  <= fwd & in_nosrc;
            out_kill <= kill;
            for (int i = 0; i < LANES; i++)
                out_npc[i*PC_W +: PC_W] <= fwd[i] ? npc_w[i] : '0;
            rd_valid     <= rd_n.valid;
            rd_tid       <= hit ? rd_n.tid : '0;
            rd_seq       <= hit ? rd_n.seq : '0;
            rd_npc       <= hit ? rd_n.npc : '0;
            rd_taken     <= hit && rd_n.taken;
            rd_ctrl_err  <= hit && rd_n.ctrl_err;
            fe_unblock   <= unblk_n;
            cnt_resolved <= cnt_resolved + CNT_W'(nres);
            cnt_mispred  <= cnt_mispred + CNT_W'(hit);
        end
    end
endmodule

// File: rtl/bru_redirect_chk.sv
module bru_redirect_chk #(
    parameter int LANES = 4,
    parameter int TID_W = 1,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [LANES-1:0]      out_vld,
    input logic [LANES-1:0]      out_kill,
    input logic                  rd_valid,
    input logic                  rd_ctrl_err,
    input logic [(1<<TID_W)-1:0] fe_unblock,
    input logic [CNT_W-1:0]      cnt_mispred
);
    AST_KILL_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (out_kill != '0) |-> rd_valid); // R5
    AST_KILL_NOT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        (out_kill & out_vld) == '0); // R5
    AST_OFFENDER_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (out_vld != '0)); // R6
    AST_UNBLOCK_ONE_THREAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fe_unblock)); // R7
    AST_UNBLOCK_WITH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (fe_unblock != '0) |-> rd_valid); // R7
    AST_CTRLERR_WITH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl_err |-> rd_valid); // R4
    AST_MISPRED_STEP: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> cnt_mispred == $past(cnt_mispred) + CNT_W'(1)); // R10
    AST_MISPRED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(cnt_mispred)); // R10
endmodule

bind bru_redirect_unit bru_redirect_chk #(
    .LANES(LANES),
    .TID_W(TID_W),
    .CNT_W(CNT_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .out_vld    (out_vld),
    .out_kill   (out_kill),
    .rd_valid   (rd_valid),
    .rd_ctrl_err(rd_ctrl_err),
    .fe_unblock (fe_unblock),
    .cnt_mispred(cnt_mispred)
);

// File: tb/test_bru_redirect_unit.sv
module test_bru_redirect_unit;
    localparam int L  = 4;
    localparam int PW = 16;
    localparam int SW = 8;
    localparam int TW = 1;
    localparam int CW = 16;
    localparam int NT = 1 << TW;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [L-1:0]    in_vld, in_skip, in_ctrl, in_direct, in_uncond, in_ptaken, in_nosrc;
    logic [L*TW-1:0] in_tid;
    logic [L*SW-1:0] in_seq;
    logic [L*PW-1:0] in_pc, in_off, in_pnpc;
    logic [NT-1:0]   thr_hold;
    logic [L-1:0]    out_vld, out_rdy, out_kill;
    logic [L*PW-1:0] out_npc;
    logic            rd_valid, rd_taken, rd_ctrl_err;
    logic [TW-1:0]   rd_tid;
    logic [SW-1:0]   rd_seq;
    logic [PW-1:0]   rd_npc;
    logic [NT-1:0]   fe_unblock;
    logic [CW-1:0]   cnt_resolved, cnt_mispred;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bru_redirect_unit #(.LANES(L), .PC_W(PW), .SEQ_W(SW), .TID_W(TW), .CNT_W(CW)) i_bru_redirect_unit (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_skip(in_skip), .in_tid(in_tid),
        .in_seq(in_seq), .in_pc(in_pc), .in_off(in_off), .in_ctrl(in_ctrl),
        .in_direct(in_direct), .in_uncond(in_uncond), .in_ptaken(in_ptaken),
        .in_pnpc(in_pnpc), .in_nosrc(in_nosrc), .thr_hold(thr_hold),
        .out_vld(out_vld), .out_npc(out_npc), .out_rdy(out_rdy), .out_kill(out_kill),
        .rd_valid(rd_valid), .rd_tid(rd_tid), .rd_seq(rd_seq), .rd_npc(rd_npc),
        .rd_taken(rd_taken), .rd_ctrl_err(rd_ctrl_err), .fe_unblock(fe_unblock),
        .cnt_resolved(cnt_resolved), .cnt_mispred(cnt_mispred)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected state
    logic [L-1:0]    e_vld, e_rdy, e_kill;
    logic [L*PW-1:0] e_npc;
    logic            e_rd, e_taken, e_cerr;
    logic [TW-1:0]   e_tid;
    logic [SW-1:0]   e_seq;
    logic [PW-1:0]   e_rnpc;
    logic [NT-1:0]   e_unb;
    logic [CW-1:0]   e_res = '0;
    logic [CW-1:0]   e_mis = '0;

    task automatic drive_idle();
        in_vld = '0; in_skip = '0; in_ctrl = '0; in_direct = '0; in_uncond = '0;
        in_ptaken = '0; in_nosrc = '0; in_tid = '0; in_seq = '0; in_pc = '0;
        in_off = '0; in_pnpc = '0; thr_hold = '0;
    endtask

    // lane kinds: 0 plain/conditional, 1 resolved correct, 2 resolved wrong,
    // 3 non-control predicted taken, 4 skipped (would be wrong if evaluated)
    task automatic drive_and_expect(input int p);
        int kind[L];
        int f = -1;
        logic [PW-1:0] pc, off, pn;
        int q = p;
        for (int i = 0; i < L; i++) begin kind[i] = q % 5; q = q / 5; end
        thr_hold = NT'(p % 4);
        for (int i = 0; i < L; i++) begin
            pc  = PW'(16'h1000 + p*16 + i*4);
            off = (p % 3 == 0) ? PW'(4) : ((p % 7 == 0) ? PW'(16'hFFF0) : PW'(16'h0100 + i*8));
            in_pc[i*PW +: PW]  = pc;
            in_off[i*PW +: PW] = off;
            in_tid[i*TW +: TW] = TW'(((p / 3) >> i) & 1);
            in_seq[i*SW +: SW] = SW'((p*7 + i*37 + ((i == 3) ? 200 : 0)) % 256);
            in_nosrc[i] = ((p + i) % 2) == 1;
            in_vld[i]   = 1'b1;
            in_skip[i]  = kind[i] == 4;
            in_ctrl[i]  = 1'b0; in_direct[i] = 1'b0; in_uncond[i] = 1'b0; in_ptaken[i] = 1'b0;
            pn = pc + PW'(4);
            case (kind[i])
                0: if (i % 2 == 1) begin
                       in_ctrl[i] = 1'b1; in_direct[i] = 1'b1; in_ptaken[i] = 1'b1;
                       pn = pc + off + PW'(4);
                   end
                1: begin in_ctrl[i] = 1'b1; in_direct[i] = 1'b1; in_uncond[i] = 1'b1;
                         in_ptaken[i] = 1'b1; pn = pc + off; end
                2, 4: begin in_ctrl[i] = 1'b1; in_direct[i] = 1'b1; in_uncond[i] = 1'b1;
                         in_ptaken[i] = 1'b1; pn = pc + off + PW'(4); end
                default: begin in_ptaken[i] = 1'b1; pn = pc + off; end
            endcase
            in_pnpc[i*PW +: PW] = pn;
        end
        // expected results
        for (int i = 0; i < L; i++)
            if (f < 0 && (kind[i] == 2 || kind[i] == 3)) f = i;
        e_rd = f >= 0;
        e_vld = '0; e_rdy = '0; e_kill = '0; e_npc = '0;
        e_tid = '0; e_seq = '0; e_rnpc = '0; e_taken = 1'b0; e_cerr = 1'b0; e_unb = '0;
        if (e_rd) begin
            e_tid  = in_tid[f*TW +: TW];
            e_seq  = in_seq[f*SW +: SW];
            e_cerr = kind[f] == 3;
            e_rnpc = (kind[f] == 3) ? in_pc[f*PW +: PW] + PW'(4)
                                    : in_pc[f*PW +: PW] + in_off[f*PW +: PW];
            e_taken = e_rnpc != in_pc[f*PW +: PW] + PW'(4);
            e_unb = thr_hold[e_tid] ? (NT'(1) << e_tid) : '0;
            e_mis = e_mis + CW'(1);
        end
        for (int i = 0; i < L; i++) begin
            if (kind[i] == 4) continue;
            if (e_rd && i > f) begin
                e_kill[i] = (in_tid[i*TW +: TW] == e_tid) && (in_seq[i*SW +: SW] > e_seq);
            end else begin
                e_vld[i] = 1'b1;
                e_rdy[i] = in_nosrc[i];
                if (kind[i] == 1 || kind[i] == 2) begin
                    e_npc[i*PW +: PW] = in_pc[i*PW +: PW] + in_off[i*PW +: PW];
                    e_res = e_res + CW'(1);
                end else if (kind[i] == 3)
                    e_npc[i*PW +: PW] = in_pc[i*PW +: PW] + PW'(4);
                else
                    e_npc[i*PW +: PW] = in_pnpc[i*PW +: PW];
            end
        end
    endtask

    task automatic check_outputs();
        chk(out_vld == e_vld,   "R6/R9 forward mask", 64'(out_vld), 64'(e_vld));
        chk(out_kill == e_kill, "R5 kill mask", 64'(out_kill), 64'(e_kill));
        chk(out_rdy == e_rdy,   "R8 ready bits", 64'(out_rdy), 64'(e_rdy));
        chk(out_npc == e_npc,   "R1 next-PC", 64'(out_npc), 64'(e_npc));
        chk(rd_valid == e_rd,   "R2 redirect valid", 64'(rd_valid), 64'(e_rd));
        if (e_rd) begin
            chk(rd_npc == e_rnpc && rd_tid == e_tid && rd_seq == e_seq, "R2 redirect record",
                {rd_tid, rd_seq, rd_npc}, {e_tid, e_seq, e_rnpc});
            chk(rd_taken == e_taken, "R3 taken bit", 64'(rd_taken), 64'(e_taken));
            chk(rd_ctrl_err == e_cerr, "R4 control error", 64'(rd_ctrl_err), 64'(e_cerr));
        end
        chk(fe_unblock == e_unb, "R7 unblock pulse", 64'(fe_unblock), 64'(e_unb));
        chk(cnt_resolved == e_res && cnt_mispred == e_mis, "R10 counters",
            {cnt_resolved, cnt_mispred}, {e_res, e_mis});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        drive_idle();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_vld == '0 && out_kill == '0 && out_rdy == '0 && !rd_valid && fe_unblock == '0
            && cnt_resolved == '0 && cnt_mispred == '0, "R11 reset state",
            {out_vld, out_kill, out_rdy, rd_valid, cnt_resolved, cnt_mispred}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_valid && out_vld == '0 && cnt_mispred == '0, "R11 after reset",
            {rd_valid, out_vld, cnt_mispred}, 64'd0);
        for (int p = 0; p < 625; p++) begin
            drive_and_expect(p);
            @(negedge clk);  // one rising edge: R11 latency
            check_outputs();
        end
        drive_idle();
        @(negedge clk);
        chk(out_vld == '0 && !rd_valid && cnt_mispred == e_mis, "R11 idle group",
            {out_vld, rd_valid, cnt_mispred}, {4'd0, 1'b0, e_mis});
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule